// File: doc/BRIEF.md
# Multi-Segment Linear Chirp Sequencer

This block produces, once per reference clock cycle, the frequency control word that a fractional-N synthesizer's modulator consumes. A frame is built from up to 32 programmable segments. Each segment carries its own mode, a signed frequency increment, a dwell (reference cycles between increments) and a step count. Triangle, sawtooth, trapezoid and mixed-slope frames all come from the same engine, and no waveform shape is fixed in the logic.

Software fills the segment table while the sequencer is idle and sets the initial frequency and the number of active segments. It then issues a start command. The sequencer loads the initial frequency and walks the active segments in order, wrapping back to segment 0 after the last one. The frame repeats until a stop command arrives. A one-cycle pulse marks every segment entry, and the current segment index is output so that downstream timing can align to it.

Top module: `chirp_seq`

## Requirements
- R1: Reset clears `fcw` to 0 and drives `running`, `seg_start`, `seg_idx` and `wr_err` to 0. While idle, `fcw` equals the `f_init` value present at the previous clock edge.
- R2: A `start_cmd` while idle (without `stop_cmd`) gives, on the next cycle, `running`=1, `seg_start`=1, `seg_idx`=0 and `fcw`=`f_init`.
- R3: Mode UP (code 0) adds the sign-extended 24-bit increment to `fcw` once every dwell cycles, modulo 2^32. Mode DOWN (code 1) subtracts it. The first change appears dwell cycles after the segment starts.
- R4: Mode HOLD (code 2) leaves `fcw` unchanged for the whole segment.
- R5: Mode RESET (code 3) sets `fcw` back to the initial frequency on each of its step ticks.
- R6: A segment lasts exactly dwell × steps cycles, with a dwell or step count of 0 treated as 1. The cycle after the last tick shows the next index together with a one-cycle `seg_start` pulse.
- R7: After the last active segment the index wraps to 0. The active count is sampled at start: 0 counts as 1 and values above 32 count as 32.
- R8: `stop_cmd` returns the block to idle on the next cycle, with `fcw`=`f_init` and `seg_idx`=0. It takes priority over `start_cmd`.
- R9: Table writes are stored only while idle. A write while running leaves the table unchanged and sets `wr_err`, which stays set until reset.
- R10: `start_cmd` while running is ignored. The frame continues without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| f_init | input | 32 | Initial frequency word |
| seg_count | input | 6 | Number of active segments (1 to 32) |
| start_cmd | input | 1 | Begin the frame from segment 0 |
| stop_cmd | input | 1 | Return to idle |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 5 | Table entry to write |
| tbl_mode | input | 2 | Segment mode: 0 up, 1 down, 2 hold, 3 reset |
| tbl_incr | input | 24 | Signed frequency increment per tick |
| tbl_dwell | input | 16 | Reference cycles per step |
| tbl_steps | input | 16 | Steps in the segment |
| fcw | output | 32 | Frequency control word to the modulator |
| seg_start | output | 1 | One-cycle pulse on each segment entry |
| seg_idx | output | 5 | Current segment index |
| running | output | 1 | Frame in progress |
| wr_err | output | 1 | Sticky flag for writes rejected while running |

## Verification
Every result is registered, so each command shows at the ports one clock edge later: start, stop and the idle tracking of `f_init` all appear in the cycle after the command. A frequency step appears dwell cycles after segment entry. An index change with its `seg_start` pulse appears dwell × steps cycles after entry. The bench applies stimulus just after a falling edge and samples half a period after each rising edge. Every expected value is indexed by the number of cycles since the start command, so each check lands exactly in the cycle these latencies predict.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;

    localparam int unsigned SEQ_INC_W   = 24;
    localparam int unsigned SEQ_DWELL_W = 16;
    localparam int unsigned SEQ_STEPS_W = 16;

    typedef enum logic [1:0] {
        SEG_UP    = 2'd0,
        SEG_DOWN  = 2'd1,
        SEG_HOLD  = 2'd2,
        SEG_RESET = 2'd3
    } seg_mode_e;

    typedef struct packed {
        seg_mode_e                mode;
        logic [SEQ_INC_W-1:0]     incr;
        logic [SEQ_DWELL_W-1:0]   dwell;
        logic [SEQ_STEPS_W-1:0]   steps;
    } seg_entry_t;

endpackage

// File: rtl/chirp_seq_table.sv
module chirp_seq_table
    import chirp_seq_pkg::*;
#(
    parameter int unsigned N_SEG = 32,
    localparam int unsigned IDX_W = $clog2(N_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_entry_t       rd_entry,
    output logic             wr_err
);

    localparam logic [IDX_W:0] NSEG_V = (IDX_W+1)'(N_SEG);

    seg_entry_t ent_d [N_SEG];
    seg_entry_t ent_q [N_SEG];
    logic       err_d, err_q;
    logic       wr_ok;

    always_comb begin
        wr_ok = wr_en && !busy && ({1'b0, wr_idx} < NSEG_V);
        err_d = err_q | (wr_en & busy);
        for (int i = 0; i < int'(N_SEG); i++) begin
            ent_d[i] = ent_q[i];
            if (wr_ok && (int'(wr_idx) == i)) begin
                ent_d[i] = wr_entry;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N_SEG); i++) begin
                ent_q[i] <= '0;
            end
            err_q <= 1'b0;
        end else begin
            for (int i = 0; i < int'(N_SEG); i++) begin
                ent_q[i] <= ent_d[i];
            end
            err_q <= err_d;
        end
    end

    assign rd_entry = ent_q[rd_idx];
    assign wr_err   = err_q;

endmodule

// File: rtl/chirp_seq_timer.sv
module chirp_seq_timer #(
    parameter int unsigned DWELL_W = 16,
    parameter int unsigned STEPS_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [DWELL_W-1:0] dwell,
    input  logic [STEPS_W-1:0] steps,
    output logic               tick,
    output logic               seg_end
);

    typedef struct packed {
        logic [DWELL_W-1:0] dwell_cnt;
        logic [STEPS_W-1:0] step_cnt;
    } tmr_t;

    tmr_t               st_d, st_q;
    logic [DWELL_W-1:0] dwell_lim;
    logic [STEPS_W-1:0] steps_lim;

    always_comb begin
        dwell_lim = (dwell == '0) ? '0 : dwell - DWELL_W'(1);
        steps_lim = (steps == '0) ? '0 : steps - STEPS_W'(1);
        tick      = !clear && (st_q.dwell_cnt >= dwell_lim);
        seg_end   = tick && (st_q.step_cnt >= steps_lim);
        st_d      = st_q;
        if (clear) begin
            st_d = '0;
        end else if (tick) begin
            st_d.dwell_cnt = '0;
            st_d.step_cnt  = seg_end ? '0 : st_q.step_cnt + STEPS_W'(1);
        end else begin
            st_d.dwell_cnt = st_q.dwell_cnt + DWELL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/chirp_seq_integ.sv
module chirp_seq_integ
    import chirp_seq_pkg::*;
#(
    parameter int unsigned FCW_W = 32,
    parameter int unsigned INC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [FCW_W-1:0] init,
    input  logic             tick,
    input  seg_mode_e        mode,
    input  logic [INC_W-1:0] incr,
    output logic [FCW_W-1:0] fcw
);

    logic [FCW_W-1:0] acc_d, acc_q;
    logic [FCW_W-1:0] inc_ext;

    always_comb begin
        inc_ext = {{(FCW_W-INC_W){incr[INC_W-1]}}, incr};
        acc_d   = acc_q;
        if (load) begin
            acc_d = init;
        end else if (tick) begin
            case (mode)
                SEG_UP:    acc_d = acc_q + inc_ext;
                SEG_DOWN:  acc_d = acc_q - inc_ext;
                SEG_HOLD:  acc_d = acc_q;
                SEG_RESET: acc_d = init;
                default:   acc_d = acc_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign fcw = acc_q;

endmodule

// File: rtl/chirp_seq.sv
module chirp_seq
    import chirp_seq_pkg::*;
#(
    parameter int unsigned N_SEG = 32,
    parameter int unsigned FCW_W = 32,
    localparam int unsigned IDX_W = $clog2(N_SEG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [FCW_W-1:0]       f_init,
    input  logic [IDX_W:0]         seg_count,
    input  logic                   start_cmd,
    input  logic                   stop_cmd,
    input  logic                   tbl_we,
    input  logic [IDX_W-1:0]       tbl_idx,
    input  logic [1:0]             tbl_mode,
    input  logic [SEQ_INC_W-1:0]   tbl_incr,
    input  logic [SEQ_DWELL_W-1:0] tbl_dwell,
    input  logic [SEQ_STEPS_W-1:0] tbl_steps,
    output logic [FCW_W-1:0]       fcw,
    output logic                   seg_start,
    output logic [IDX_W-1:0]       seg_idx,
    output logic                   running,
    output logic                   wr_err
);

    localparam logic [IDX_W:0] NSEG_V = (IDX_W+1)'(N_SEG);

    typedef struct packed {
        logic             run;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic             seg_start;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    seg_entry_t wr_entry, cur;
    logic       tmr_clear, tmr_tick, tmr_end;
    logic       integ_load, integ_tick;
    logic       go;

    assign wr_entry = '{mode: seg_mode_e'(tbl_mode), incr: tbl_incr,
                        dwell: tbl_dwell, steps: tbl_steps};

    chirp_seq_table #(.N_SEG(N_SEG)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (ctl_q.run),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_entry (wr_entry),
        .rd_idx   (ctl_q.idx),
        .rd_entry (cur),
        .wr_err   (wr_err)
    );

    chirp_seq_timer #(.DWELL_W(SEQ_DWELL_W), .STEPS_W(SEQ_STEPS_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .dwell   (cur.dwell),
        .steps   (cur.steps),
        .tick    (tmr_tick),
        .seg_end (tmr_end)
    );

    chirp_seq_integ #(.FCW_W(FCW_W), .INC_W(SEQ_INC_W)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (integ_load),
        .init  (f_init),
        .tick  (integ_tick),
        .mode  (cur.mode),
        .incr  (cur.incr),
        .fcw   (fcw)
    );

    always_comb begin
        go         = !ctl_q.run && start_cmd && !stop_cmd;
        tmr_clear  = !ctl_q.run || stop_cmd;
        integ_load = !ctl_q.run || stop_cmd;
        integ_tick = tmr_tick && ctl_q.run && !stop_cmd;

        ctl_d           = ctl_q;
        ctl_d.seg_start = 1'b0;
        if (stop_cmd) begin
            ctl_d.run = 1'b0;
            ctl_d.idx = '0;
        end else if (go) begin
            ctl_d.run       = 1'b1;
            ctl_d.idx       = '0;
            ctl_d.seg_start = 1'b1;
            if (seg_count == '0)          ctl_d.last = '0;
            else if (seg_count > NSEG_V)  ctl_d.last = IDX_W'(N_SEG - 1);
            else                          ctl_d.last = IDX_W'(seg_count - 1'b1);
        end else if (ctl_q.run && tmr_end) begin
            ctl_d.idx       = (ctl_q.idx == ctl_q.last) ? '0 : ctl_q.idx + 1'b1;
            ctl_d.seg_start = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign seg_start = ctl_q.seg_start;
    assign seg_idx   = ctl_q.idx;
    assign running   = ctl_q.run;

endmodule

// File: rtl/chirp_seq_chk.sv
module chirp_seq_chk #(
    parameter int unsigned FCW_W = 32,
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [FCW_W-1:0] f_init,
    input logic             start_cmd,
    input logic             stop_cmd,
    input logic             tbl_we,
    input logic [FCW_W-1:0] fcw,
    input logic             seg_start,
    input logic [IDX_W-1:0] seg_idx,
    input logic             running,
    input logic             wr_err
);

    p_idle_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_cmd) |=> (fcw == $past(f_init)));

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && start_cmd && !stop_cmd) |=>
        (running && seg_start && seg_idx == '0 && fcw == $past(f_init)));

    p_idx_moves_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stop_cmd) |=> (seg_start || seg_idx == $past(seg_idx)));

    p_pulse_when_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seg_start |-> running);

    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (!running && seg_idx == '0 && fcw == $past(f_init)));

    p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && running) |=> wr_err);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start_cmd && !stop_cmd) |=> running);

endmodule

bind chirp_seq chirp_seq_chk #(.FCW_W(FCW_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .f_init    (f_init),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd),
    .tbl_we    (tbl_we),
    .fcw       (fcw),
    .seg_start (seg_start),
    .seg_idx   (seg_idx),
    .running   (running),
    .wr_err    (wr_err)
);

// File: tb/chirp_seq_bench.sv
module chirp_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] f_init;
    logic [5:0]  seg_count;
    logic        start_cmd, stop_cmd, tbl_we;
    logic [4:0]  tbl_idx;
    logic [1:0]  tbl_mode;
    logic [23:0] tbl_incr;
    logic [15:0] tbl_dwell, tbl_steps;
    logic [31:0] fcw;
    logic        seg_start, running, wr_err;
    logic [4:0]  seg_idx;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // Frame: seg0 up +10 dwell2x3, seg1 hold dwell3x1, seg2 down 5 dwell1x2, seg3 reset 1x1
    localparam int NV = 15;
    localparam int unsigned V_FCW [NV] = '{1000,1000,1010,1010,1020,1020,1030,1030,
                                           1030,1030,1025,1020,1000,1000,1010};
    localparam int unsigned V_IDX [NV] = '{0,0,0,0,0,0,1,1,1,2,2,3,0,0,0};
    localparam int unsigned V_SS  [NV] = '{1,0,0,0,0,0,1,0,0,1,0,1,1,0,0};

    chirp_seq u_chirp_seq (
        .clk(clk), .rst_n(rst_n), .f_init(f_init), .seg_count(seg_count),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_mode(tbl_mode), .tbl_incr(tbl_incr),
        .tbl_dwell(tbl_dwell), .tbl_steps(tbl_steps), .fcw(fcw),
        .seg_start(seg_start), .seg_idx(seg_idx), .running(running),
        .wr_err(wr_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog all-reqs actual %0d cycles expected completion", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int mode, input logic [23:0] inc,
                      input int dw, input int st);
        tbl_we = 1'b1; tbl_idx = 5'(idx); tbl_mode = 2'(mode);
        tbl_incr = inc; tbl_dwell = 16'(dw); tbl_steps = 16'(st);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic do_start();
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
    endtask

    task automatic do_stop();
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; f_init = '0; seg_count = '0; start_cmd = 0; stop_cmd = 0;
        tbl_we = 0; tbl_idx = '0; tbl_mode = '0; tbl_incr = '0;
        tbl_dwell = '0; tbl_steps = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset fcw", fcw, 0);
        chk("R1 reset running", {31'b0, running}, 0);
        chk("R1 reset seg_start", {31'b0, seg_start}, 0);
        chk("R1 reset seg_idx", {27'b0, seg_idx}, 0);
        chk("R1 reset wr_err", {31'b0, wr_err}, 0);
        rst_n = 1'b1; f_init = 1000; seg_count = 4;
        @(negedge clk);
        chk("R1 idle tracks f_init", fcw, 1000);
        f_init = 5000;
        @(negedge clk);
        chk("R1 idle tracks new f_init", fcw, 5000);
        f_init = 1000;
        @(negedge clk);

        wr(0, 0, 24'd10, 2, 3);
        wr(1, 2, 24'd77, 3, 1);
        wr(2, 1, 24'd5, 1, 2);
        wr(3, 3, 24'd0, 1, 1);
        chk("R9 idle writes raise no error", {31'b0, wr_err}, 0);

        // Vector walk: R2 start, R3 up/down, R4 hold, R5 reset, R6 timing, R7 wrap
        do_start();
        for (int t = 0; t < NV; t++) begin
            if (t > 0) @(negedge clk);
            chk($sformatf("R3/R4/R5 vec %0d fcw", t), fcw, V_FCW[t]);
            chk($sformatf("R6/R7 vec %0d seg_idx", t), {27'b0, seg_idx}, V_IDX[t]);
            chk($sformatf("R6 R2 vec %0d seg_start", t), {31'b0, seg_start}, V_SS[t]);
        end

        // R8: stop wins over a simultaneous start
        start_cmd = 1'b1; stop_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0; stop_cmd = 1'b0;
        chk("R8 stop running", {31'b0, running}, 0);
        chk("R8 stop fcw", fcw, 1000);
        chk("R8 stop seg_idx", {27'b0, seg_idx}, 0);
        chk("R8 stop seg_start", {31'b0, seg_start}, 0);

        // R10: start while running does not restart
        do_start();
        repeat (3) @(negedge clk);
        chk("R10 before restart fcw", fcw, 1010);
        do_start();
        chk("R10 restart ignored fcw", fcw, 1020);
        chk("R10 restart ignored seg_start", {31'b0, seg_start}, 0);
        chk("R10 still running", {31'b0, running}, 1);

        // R9: write while running is dropped and flagged
        wr(0, 0, 24'd100, 2, 3);
        chk("R9 err set", {31'b0, wr_err}, 1);
        do_stop();
        do_start();
        repeat (2) @(negedge clk);
        chk("R9 entry unchanged", fcw, 1010);
        do_stop();
        wr(0, 0, 24'd20, 2, 3);
        chk("R9 err sticky", {31'b0, wr_err}, 1);
        do_start();
        repeat (2) @(negedge clk);
        chk("R9 idle write applied", fcw, 1020);
        do_stop();

        // R3 negative increment with wrap, R6 dwell 0, R7 count 0 clamps to 1
        wr(0, 0, 24'hFFFFFD, 0, 4);
        seg_count = 0; f_init = 1;
        @(negedge clk);
        do_start();
        chk("R2 start fcw", fcw, 1);
        @(negedge clk);
        chk("R3 negative step wraps", fcw, 32'hFFFFFFFE);
        repeat (3) @(negedge clk);
        chk("R3 after four steps", fcw, 32'hFFFFFFF5);
        chk("R7 single segment wraps seg_start", {31'b0, seg_start}, 1);
        chk("R7 single segment idx", {27'b0, seg_idx}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule